// File: doc/BRIEF.md
# Dual-Output Glitch-Free Clock Selector

This block produces two clock outputs. Each one runs either from a standby clock that both outputs share or from its own PLL output clock. A select field chooses the source, with one bit per output. Bit 0 steers output 0 and bit 1 steers output 1. A value of 00 leaves both outputs on standby and 11 puts both on their PLL clocks. The standby clock is itself chosen by one more bit, either the bus clock (the default) or an alternate clock. That choice is also made without glitches.

Every change of source uses break-before-make. The enable of the old clock passes through a synchroniser in the old clock's domain and drops on that clock's falling edge. Only after that does the enable of the new clock pass through its own synchroniser and rise on the new clock's falling edge. No output ever shows a shortened high phase. If a requested PLL clock is not toggling, the output stays low and a pending flag stays up until the clock starts. A PLL request takes effect only while the PLL lock input is high. Per-output status flags, synchronised to the bus clock, report which source is in use.

Top module: `dual_clk_selector`

## Requirements
- R1: With lock high, sel[0]=1 drives clk_out[0] from pll_clk[0], and sel[0]=0 drives it from the standby clock.
- R2: With lock high, sel[1]=1 drives clk_out[1] from pll_clk[1], and sel[1]=0 drives it from the standby clock.
- R3: After reset, both outputs run from the bus clock and pll_active, switch_pending and stby_alt_active are all 0.
- R4: stby_src=0 makes the standby clock the bus clock and stby_src=1 makes it alt_clk. stby_alt_active reads 1 exactly when alt_clk is the standby source in use.
- R5: While pll_lock is 0, every PLL request is treated as standby. When lock returns, the pending requests take effect.
- R6: Every high phase on clk_out[i] lasts exactly half the period of one of that output's sources. No high phase is ever shortened.
- R7: Switching is break-before-make. The incoming enable never rises while the outgoing one is still set, so every low phase on clk_out[i] lasts at least half the period of pll_clk[i].
- R8: If the requested pll_clk[i] is not toggling, clk_out[i] stays low with no edges, pll_active[i]=0 and switch_pending[i]=1. Once that clock runs, the switch completes.
- R9: pll_active[i] is 1 when the PLL enable of output i is set, seen through a bus-clock synchroniser. switch_pending[i] is 1 while the lock-qualified request differs from pll_active[i]. After a change, both settle within 40 bus clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released in step with bus_clk |
| bus_clk | input | 1 | Register clock and default standby source |
| alt_clk | input | 1 | Alternate standby source |
| pll_clk | input | 2 | PLL output clocks, bit i for output i |
| pll_lock | input | 1 | PLL lock indication, qualifies PLL requests |
| sel | input | 2 | Source select, bit i = 1 picks pll_clk[i] for clk_out[i] |
| stby_src | input | 1 | Standby source select: 0 bus_clk, 1 alt_clk |
| clk_out | output | 2 | Switched clock outputs |
| pll_active | output | 2 | Bit i = 1 when clk_out[i] runs from its PLL clock |
| switch_pending | output | 2 | Bit i = 1 while a source change of output i is unfinished |
| stby_alt_active | output | 1 | 1 when the standby clock runs from alt_clk |

## Verification
The bench builds the block with its defaults: two outputs and two synchroniser stages. With so few select and standby states, every transition between any two of the four select values can be covered for both standby sources. The bench uses four clocks with unrelated periods of 20, 26, 7 and 11 ns. As a result, the edges of the old and new clocks fall in many different relative phases, and every high and low phase on both outputs is measured against the half periods the bench expects. A stopped PLL clock and a lock that is withheld show the hold-low and the lock-gating behaviour at the ports.

// File: rtl/dual_clk_pkg.sv
`timescale 1ns/1ps
package dual_clk_pkg;
  localparam int unsigned SYNC_DEPTH_DEF = 2;
  localparam int unsigned NOUT_DEF       = 2;

  typedef enum logic {
    SRC_STANDBY = 1'b0,
    SRC_PLL     = 1'b1
  } src_e;
endpackage

// File: rtl/bit_sync.sv
`timescale 1ns/1ps
module bit_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/glitchless_switch.sv
`timescale 1ns/1ps
module glitchless_switch #(
  parameter int unsigned STAGES = 2
) (
  input  logic rst_n,
  input  logic clk_a,
  input  logic clk_b,
  input  logic pick_b,
  output logic clk_o,
  output logic en_b_o
);
  logic want_a, want_b;
  logic a_sync, b_sync;
  logic en_a_q, en_b_q;

  // A side is allowed only when B is off, and B only when A is off.
  always_comb begin
    want_a = ~pick_b & ~en_b_q;
    want_b =  pick_b & ~en_a_q;
  end

  bit_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync_a (
    .clk(clk_a), .rst_n(rst_n), .d(want_a), .q(a_sync)
  );

  bit_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync_b (
    .clk(clk_b), .rst_n(rst_n), .d(want_b), .q(b_sync)
  );

  // Enables change on falling edges, while their own clock is low.
  always_ff @(negedge clk_a or negedge rst_n) begin
    if (!rst_n) en_a_q <= 1'b1;
    else        en_a_q <= a_sync;
  end

  always_ff @(negedge clk_b or negedge rst_n) begin
    if (!rst_n) en_b_q <= 1'b0;
    else        en_b_q <= b_sync;
  end

  assign clk_o  = (clk_a & en_a_q) | (clk_b & en_b_q);
  assign en_b_o = en_b_q;

  // R7: the two enables are never set together
  always_comb begin
    if (rst_n) begin
      p_no_overlap_r7: assert (!(en_a_q && en_b_q))
        else $error("both clock enables set");
    end
  end

  // R7: B turns on only with A already off
  p_b_rise_clean_r7: assert property (@(negedge clk_b) disable iff (!rst_n)
    $rose(en_b_q) |-> !en_a_q);

  // R7: A turns on only with B already off
  p_a_rise_clean_r7: assert property (@(negedge clk_a) disable iff (!rst_n)
    $rose(en_a_q) |-> !en_b_q);

  // R7: sampled in A's domain, A stays off while B is on
  p_a_held_off_r7: assert property (@(negedge clk_a) disable iff (!rst_n)
    en_b_q |-> !en_a_q);
endmodule

// File: rtl/dual_clk_selector.sv
`timescale 1ns/1ps
module dual_clk_selector
  import dual_clk_pkg::*;
#(
  parameter int unsigned NOUT        = NOUT_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH_DEF
) (
  input  logic            rst_n,
  input  logic            bus_clk,
  input  logic            alt_clk,
  input  logic [NOUT-1:0] pll_clk,
  input  logic            pll_lock,
  input  logic [NOUT-1:0] sel,
  input  logic            stby_src,
  output logic [NOUT-1:0] clk_out,
  output logic [NOUT-1:0] pll_active,
  output logic [NOUT-1:0] switch_pending,
  output logic            stby_alt_active
);
  localparam int unsigned NSTAT = NOUT + 1;

  logic [NOUT-1:0]  req_d, req_q;
  logic             stby_d, stby_q;
  logic             stby_clk;
  logic             stby_en_alt;
  logic [NOUT-1:0]  pll_en;
  logic [NSTAT-1:0] stat_raw, stat_sync;

  // Lock-qualified request register in the bus clock domain.
  always_comb begin
    req_d  = sel & {NOUT{pll_lock}};
    stby_d = stby_src;
  end

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      stby_q <= SRC_STANDBY;
    end else begin
      req_q  <= req_d;
      stby_q <= stby_d;
    end
  end

  // Standby source: bus clock or alternate clock, glitch-free.
  glitchless_switch #(.STAGES(SYNC_STAGES)) u_stby_sw (
    .rst_n (rst_n),
    .clk_a (bus_clk),
    .clk_b (alt_clk),
    .pick_b(stby_q),
    .clk_o (stby_clk),
    .en_b_o(stby_en_alt)
  );

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    glitchless_switch #(.STAGES(SYNC_STAGES)) u_sw (
      .rst_n (rst_n),
      .clk_a (stby_clk),
      .clk_b (pll_clk[g]),
      .pick_b(req_q[g]),
      .clk_o (clk_out[g]),
      .en_b_o(pll_en[g])
    );
  end

  assign stat_raw = {stby_en_alt, pll_en};

  for (genvar s = 0; s < NSTAT; s++) begin : g_stat
    bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_stat (
      .clk(bus_clk), .rst_n(rst_n), .d(stat_raw[s]), .q(stat_sync[s])
    );
  end

  assign pll_active      = stat_sync[NOUT-1:0];
  assign stby_alt_active = stat_sync[NOUT];
  assign switch_pending  = req_q ^ pll_active;
endmodule

// File: tb/dual_clk_selector_test.sv
`timescale 1ns/1ps
module dual_clk_selector_test;
  logic       rst_n, bus_clk, alt_clk, pll_lock, stby_src;
  logic [1:0] pll_clk, sel, clk_out, pll_active, switch_pending;
  logic       stby_alt_active;
  bit         pll1_run;
  bit         mon_en;

  int checks = 0;
  int errors = 0;

  real last_rise [2];
  real prev_rise [2];
  real last_fall [2];
  bit  have_rise [2];
  bit  have_fall [2];
  int  rises     [2];

  localparam real P_BUS = 20.0;
  localparam real P_ALT = 26.0;
  localparam real P_PLL0 = 7.0;
  localparam real P_PLL1 = 11.0;

  dual_clk_selector uut (
    .rst_n(rst_n), .bus_clk(bus_clk), .alt_clk(alt_clk), .pll_clk(pll_clk),
    .pll_lock(pll_lock), .sel(sel), .stby_src(stby_src), .clk_out(clk_out),
    .pll_active(pll_active), .switch_pending(switch_pending),
    .stby_alt_active(stby_alt_active)
  );

  initial begin bus_clk = 1'b0; forever #10 bus_clk = ~bus_clk; end
  initial begin alt_clk = 1'b0; forever #13 alt_clk = ~alt_clk; end
  initial begin pll_clk[0] = 1'b0; forever #3.5 pll_clk[0] = ~pll_clk[0]; end
  initial begin
    pll_clk[1] = 1'b0;
    forever begin
      #5.5;
      pll_clk[1] = pll1_run ? ~pll_clk[1] : 1'b0;
    end
  end

  function automatic bit near(real a, real b);
    return (a > b - 0.01) && (a < b + 0.01);
  endfunction

  function automatic real pll_half(int i);
    return (i == 0) ? P_PLL0 / 2.0 : P_PLL1 / 2.0;
  endfunction

  task automatic chk_int(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_real(string req, real act, real exp);
    checks++;
    if (!near(act, exp)) begin
      errors++;
      $display("FAIL %s actual %0.3f expected %0.3f", req, act, exp);
    end
  endtask

  // High phase must equal a half period of one of the output's sources (R6).
  task automatic on_fall(int i);
    real w;
    w = $realtime - last_rise[i];
    if (mon_en && have_rise[i]) begin
      checks++;
      if (!(near(w, P_BUS / 2.0) || near(w, P_ALT / 2.0) || near(w, pll_half(i)))) begin
        errors++;
        $display("FAIL R6 out%0d high phase actual %0.3f expected a source half period", i, w);
      end
    end
    last_fall[i] = $realtime;
    have_fall[i] = 1'b1;
  endtask

  // Low phase never shorter than the PLL half period (R7).
  task automatic on_rise(int i);
    real w;
    w = $realtime - last_fall[i];
    if (mon_en && have_fall[i]) begin
      checks++;
      if (w < pll_half(i) - 0.01) begin
        errors++;
        $display("FAIL R7 out%0d low phase actual %0.3f expected >= %0.3f", i, w, pll_half(i));
      end
    end
    prev_rise[i] = last_rise[i];
    last_rise[i] = $realtime;
    have_rise[i] = 1'b1;
    rises[i]++;
  endtask

  always @(posedge clk_out[0]) on_rise(0);
  always @(negedge clk_out[0]) on_fall(0);
  always @(posedge clk_out[1]) on_rise(1);
  always @(negedge clk_out[1]) on_fall(1);

  task automatic settle();
    repeat (40) @(posedge bus_clk);
    @(negedge bus_clk);
  endtask

  task automatic check_state(logic [1:0] exp_sel, logic exp_stby, string tag);
    real stby_p;
    real exp_p0, exp_p1;
    stby_p = exp_stby ? P_ALT : P_BUS;
    exp_p0 = exp_sel[0] ? P_PLL0 : stby_p;
    exp_p1 = exp_sel[1] ? P_PLL1 : stby_p;
    chk_int(pll_active[0] == exp_sel[0], {"R1 R9 active0 ", tag}, pll_active[0], exp_sel[0]);
    chk_int(pll_active[1] == exp_sel[1], {"R2 R9 active1 ", tag}, pll_active[1], exp_sel[1]);
    chk_int(switch_pending == 2'b00, {"R9 pending ", tag}, switch_pending, 0);
    chk_int(stby_alt_active == exp_stby, {"R4 stby status ", tag}, stby_alt_active, exp_stby);
    chk_real({"R1 R4 out0 period ", tag}, last_rise[0] - prev_rise[0], exp_p0);
    chk_real({"R2 R4 out1 period ", tag}, last_rise[1] - prev_rise[1], exp_p1);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r1;
    pll1_run = 1'b1;
    mon_en   = 1'b0;
    rst_n    = 1'b0;
    sel      = 2'b00;
    stby_src = 1'b0;
    pll_lock = 1'b0;
    for (int i = 0; i < 2; i++) begin
      have_rise[i] = 1'b0; have_fall[i] = 1'b0; rises[i] = 0;
      last_rise[i] = 0.0; prev_rise[i] = 0.0; last_fall[i] = 0.0;
    end
    repeat (5) @(posedge bus_clk);
    @(negedge bus_clk);
    rst_n = 1'b1;
    settle();
    // R3: reset state, both outputs on the bus clock
    check_state(2'b00, 1'b0, "after reset R3");
    chk_int(switch_pending == 2'b00, "R3 pending", switch_pending, 0);
    mon_en = 1'b1;

    // R5: requests withheld while lock is low
    sel = 2'b11;
    settle();
    check_state(2'b00, 1'b0, "no lock R5");
    pll_lock = 1'b1;
    settle();
    check_state(2'b11, 1'b0, "lock back R5");

    // Full sweep of select transitions for both standby sources.
    for (int s = 0; s < 2; s++) begin
      for (int f = 0; f < 4; f++) begin
        for (int t = 0; t < 4; t++) begin
          stby_src = s[0];
          sel = f[1:0];
          settle();
          check_state(f[1:0], s[0], "sweep from");
          sel = t[1:0];
          settle();
          check_state(t[1:0], s[0], "sweep to");
        end
      end
    end

    // R4: standby source flips while both outputs idle on standby
    sel = 2'b00;
    stby_src = 1'b1;
    settle();
    check_state(2'b00, 1'b1, "stby alt R4");
    stby_src = 1'b0;
    settle();
    check_state(2'b00, 1'b0, "stby bus R4");

    // R8: request a stopped PLL clock
    pll1_run = 1'b0;
    repeat (4) @(posedge bus_clk);
    @(negedge bus_clk);
    sel = 2'b10;
    settle();
    r1 = rises[1];
    repeat (40) @(posedge bus_clk);
    @(negedge bus_clk);
    chk_int(rises[1] == r1, "R8 no edges on dead switch", rises[1] - r1, 0);
    chk_int(clk_out[1] == 1'b0, "R8 output held low", clk_out[1], 0);
    chk_int(switch_pending[1] == 1'b1, "R8 pending set", switch_pending[1], 1);
    chk_int(pll_active[1] == 1'b0, "R8 not active", pll_active[1], 0);
    chk_real("R8 out0 unaffected", last_rise[0] - prev_rise[0], P_BUS);
    pll1_run = 1'b1;
    settle();
    check_state(2'b10, 1'b0, "dead clock restored R8");

    sel = 2'b00;
    settle();
    check_state(2'b00, 1'b0, "final");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule